// File: doc/BRIEF.md
# JTAG Scan Sequencer

This block is the host side of a JTAG link. It keeps a model of the 16-state TAP controller, and for each command it produces a stream of TCK steps. Each step carries one TMS bit, one TDI bit and a capture flag. The command types are a test-logic reset, a register access and a chain selection.

A register access loads an instruction first, but only when it has to. It then shifts a data word through the selected device. The other devices on the chain are covered by bypass padding on either side. TDO bits taken during capture-flagged steps come back as a bit stream, least significant bit first, with a flag on the last bit.

Moves between TAP states follow a per-state rule that picks the TMS value leading toward a goal state. Because of this rule, every move goes through the fewest legal states. The selection command latches the following, which then apply to all later accesses:

- the instruction length of the target device,
- the padding counts for the instruction scan and the data scan,
- the number of idle cycles after each access.

Top module: `jtag_scan_seq`

## Requirements
- R1: A reset command (op 0) emits six steps with TMS 1,1,1,1,1,0 and TDI 0, leaving the tracked TAP state in Run-Test/Idle.
- R2: Moves use the shortest TMS path. Test-Logic-Reset steps with 0 and Run-Test/Idle steps with 1. A Select state steps with 0 only toward its own arm. Update steps with 1 toward a scan arm and with 0 otherwise. On every move step TDI is 0 and capture is off.
- R3: The instruction scan has three parts, sent in order: ir_pre one-bits, then the address, least significant bit first over ir_len bits, then ir_post one-bits. TMS is 0 on every bit except the final one, where it is 1. One further TMS=1 step reaches Update-IR.
- R4: The data scan has three parts, sent in order: dr_pre zero-bits, then cmd_len data bits, least significant bit first, then dr_post zero-bits. TMS is 1 only on its final bit. One further TMS=1 step reaches Update-DR.
- R5: The capture flag is 1 only on the data payload bits of a data scan. It is 0 on padding, on instruction bits and on move steps.
- R6: With a non-zero idle count, the Update-DR step is followed by one TMS=0 step into Run-Test/Idle and then by idle-count TMS=0 steps. With a zero idle count, the access ends in Update-DR.
- R7: An access (op 1) whose address equals the last loaded instruction skips the instruction scan. After reset, the last loaded instruction is 1.
- R8: An access with address above 2^ir_len−1, with length 0, or with length above DATA_W is rejected: cmd_rej_o pulses for one cycle and no step is emitted. Until the first selection, ir_len is 4, which gives a maximum address of 15.
- R9: One cycle after each capture-flagged step, rsp_valid_o is 1 and rsp_bit_o holds the TDO value present during that step. rsp_last_o is 1 only for the final payload bit.
- R10: A select command (op 2) latches the chain and idle settings from the cfg inputs, emits no step, and governs all later accesses.
- R11: cmd_ready_o is 1 only while no command is in progress. After reset it is 1, with no step, response or reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer free to accept a command |
| cmd_op_i | input | 2 | 0 reset, 1 access, 2 select, 3 ignored |
| cmd_addr_i | input | ADDR_W | Instruction (register address) for an access |
| cmd_data_i | input | DATA_W | Data word, LSB shifted first |
| cmd_len_i | input | LEN_W | Data length in bits |
| cfg_ir_len_i | input | IRL_W | Instruction length of target device |
| cfg_ir_pre_i | input | PAD_W | Bypass bits before the instruction |
| cfg_ir_post_i | input | PAD_W | Bypass bits after the instruction |
| cfg_dr_pre_i | input | PAD_W | Bypass bits before the data |
| cfg_dr_post_i | input | PAD_W | Bypass bits after the data |
| cfg_idle_i | input | IDLE_W | Idle cycles after each access |
| cmd_rej_o | output | 1 | Pulse: access rejected |
| step_valid_o | output | 1 | One TCK step is presented this cycle |
| step_tms_o | output | 1 | TMS for the step |
| step_tdi_o | output | 1 | TDI for the step |
| step_cap_o | output | 1 | TDO of this step is to be captured |
| tdo_i | input | 1 | TDO belonging to the presented step |
| rsp_valid_o | output | 1 | Captured bit valid |
| rsp_bit_o | output | 1 | Captured TDO bit |
| rsp_last_o | output | 1 | Final captured bit of the access |

## Verification
A wrong tracked TAP state shows at the ports by the very next move step. It gives either a TMS sequence longer or shorter than the shortest path, or capture flags on steps outside the data shift. A stale or wrongly updated last-instruction register shows as an instruction scan that appears or disappears on the next access to the same address. Padding-count or length errors shift the payload against the capture window. That misalignment corrupts the returned bits, or moves rsp_last_o, within the same access.

// File: rtl/jseq_pkg.sv
package jseq_pkg;

    typedef enum logic [3:0] {
        TAP_RESET, TAP_IDLE,
        DR_SEL, DR_CAP, DR_SHIFT, DR_EXIT1, DR_PAUSE, DR_EXIT2, DR_UPD,
        IR_SEL, IR_CAP, IR_SHIFT, IR_EXIT1, IR_PAUSE, IR_EXIT2, IR_UPD
    } tap_st_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_RST, PH_IR_GO, PH_IR_SH, PH_IR_UP,
        PH_DR_GO, PH_DR_SH, PH_DR_UP, PH_TO_RTI, PH_WAIT
    } phase_e;

    localparam logic [1:0] OP_RESET  = 2'd0;
    localparam logic [1:0] OP_ACCESS = 2'd1;
    localparam logic [1:0] OP_SELECT = 2'd2;

    localparam int RST_ONES = 5;

    function automatic logic in_dr(tap_st_e s);
        return s inside {DR_SEL, DR_CAP, DR_SHIFT, DR_EXIT1, DR_PAUSE, DR_EXIT2, DR_UPD};
    endfunction

    function automatic logic in_ir(tap_st_e s);
        return s inside {IR_SEL, IR_CAP, IR_SHIFT, IR_EXIT1, IR_PAUSE, IR_EXIT2, IR_UPD};
    endfunction

    // Standard TAP controller transition.
    function automatic tap_st_e tap_next(tap_st_e s, logic tms);
        case (s)
            TAP_RESET: return tms ? TAP_RESET : TAP_IDLE;
            TAP_IDLE:  return tms ? DR_SEL    : TAP_IDLE;
            DR_SEL:    return tms ? IR_SEL    : DR_CAP;
            DR_CAP:    return tms ? DR_EXIT1  : DR_SHIFT;
            DR_SHIFT:  return tms ? DR_EXIT1  : DR_SHIFT;
            DR_EXIT1:  return tms ? DR_UPD    : DR_PAUSE;
            DR_PAUSE:  return tms ? DR_EXIT2  : DR_PAUSE;
            DR_EXIT2:  return tms ? DR_UPD    : DR_SHIFT;
            DR_UPD:    return tms ? DR_SEL    : TAP_IDLE;
            IR_SEL:    return tms ? TAP_RESET : IR_CAP;
            IR_CAP:    return tms ? IR_EXIT1  : IR_SHIFT;
            IR_SHIFT:  return tms ? IR_EXIT1  : IR_SHIFT;
            IR_EXIT1:  return tms ? IR_UPD    : IR_PAUSE;
            IR_PAUSE:  return tms ? IR_EXIT2  : IR_PAUSE;
            IR_EXIT2:  return tms ? IR_UPD    : IR_SHIFT;
            default:   return tms ? DR_SEL    : TAP_IDLE;
        endcase
    endfunction

    // TMS value that moves one state closer to tgt (cur != tgt assumed).
    function automatic logic step_tms(tap_st_e cur, tap_st_e tgt);
        tap_st_e inner;
        case (cur)
            TAP_RESET: return 1'b0;
            TAP_IDLE:  return 1'b1;
            DR_SEL:    return !in_dr(tgt);
            IR_SEL:    return !in_ir(tgt);
            DR_UPD, IR_UPD: return in_dr(tgt) || in_ir(tgt);
            DR_CAP, DR_EXIT1, DR_EXIT2: begin
                inner = in_dr(tgt) ? tgt : DR_UPD;
                if (cur == DR_CAP)   return !(inner == DR_SHIFT);
                if (cur == DR_EXIT1) return !(inner inside {DR_PAUSE, DR_EXIT2});
                return !(inner inside {DR_SHIFT, DR_EXIT1, DR_PAUSE});
            end
            IR_CAP, IR_EXIT1, IR_EXIT2: begin
                inner = in_ir(tgt) ? tgt : IR_UPD;
                if (cur == IR_CAP)   return !(inner == IR_SHIFT);
                if (cur == IR_EXIT1) return !(inner inside {IR_PAUSE, IR_EXIT2});
                return !(inner inside {IR_SHIFT, IR_EXIT1, IR_PAUSE});
            end
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/jseq_tap_track.sv
module jseq_tap_track
    import jseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv_i,
    input  logic    tms_i,
    output tap_st_e state_o
);
    tap_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) st_d = tap_next(st_q, tms_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TAP_RESET;
        else        st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/jseq_nav.sv
module jseq_nav
    import jseq_pkg::*;
(
    input  tap_st_e cur_i,
    input  tap_st_e tgt_i,
    output logic    at_tgt_o,
    output logic    tms_o
);
    assign at_tgt_o = (cur_i == tgt_i);
    assign tms_o    = step_tms(cur_i, tgt_i);
endmodule

// File: rtl/jseq_shift_gen.sv
module jseq_shift_gen #(
    parameter int DATA_W = 32,
    parameter int PAD_W  = 4,
    parameter int CW     = 8
) (
    input  logic [CW-1:0]     idx_i,
    input  logic [PAD_W-1:0]  pre_i,
    input  logic [CW-1:0]     nbits_i,
    input  logic [PAD_W-1:0]  post_i,
    input  logic [DATA_W-1:0] payload_i,
    input  logic              pad_one_i,
    input  logic              cap_en_i,
    output logic              tms_o,
    output logic              tdi_o,
    output logic              cap_o,
    output logic              cap_last_o
);
    logic [CW-1:0]     pre_w, pay_end, total, off;
    logic [DATA_W-1:0] shifted;
    logic              in_pay;

    always_comb begin
        pre_w   = CW'(pre_i);
        pay_end = pre_w + nbits_i;
        total   = pay_end + CW'(post_i);
        off     = idx_i - pre_w;
        shifted = payload_i >> off;
        in_pay  = (idx_i >= pre_w) && (idx_i < pay_end);
        tdi_o   = in_pay ? shifted[0] : pad_one_i;
        tms_o   = (idx_i == total - CW'(1));
        cap_o   = cap_en_i && in_pay;
        cap_last_o = cap_o && (idx_i == pay_end - CW'(1));
    end
endmodule

// File: rtl/jseq_rsp.sv
module jseq_rsp (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic bit_i,
    input  logic last_i,
    output logic valid_o,
    output logic bit_o,
    output logic last_o
);
    typedef struct packed {
        logic vld;
        logic b;
        logic lst;
    } rsp_t;

    rsp_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.vld = take_i;
        r_d.lst = take_i && last_i;
        if (take_i) r_d.b = bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid_o = r_q.vld;
    assign bit_o   = r_q.b;
    assign last_o  = r_q.lst;
endmodule

// File: rtl/jtag_scan_seq.sv
module jtag_scan_seq
    import jseq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int PAD_W  = 4,
    parameter int IDLE_W = 8,
    localparam int LEN_W = $clog2(DATA_W + 1),
    localparam int IRL_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [1:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    input  logic [LEN_W-1:0]  cmd_len_i,
    input  logic [IRL_W-1:0]  cfg_ir_len_i,
    input  logic [PAD_W-1:0]  cfg_ir_pre_i,
    input  logic [PAD_W-1:0]  cfg_ir_post_i,
    input  logic [PAD_W-1:0]  cfg_dr_pre_i,
    input  logic [PAD_W-1:0]  cfg_dr_post_i,
    input  logic [IDLE_W-1:0] cfg_idle_i,
    output logic              cmd_rej_o,
    output logic              step_valid_o,
    output logic              step_tms_o,
    output logic              step_tdi_o,
    output logic              step_cap_o,
    input  logic              tdo_i,
    output logic              rsp_valid_o,
    output logic              rsp_bit_o,
    output logic              rsp_last_o
);
    localparam int SHW = $clog2(2 * (2 ** PAD_W) + DATA_W + ADDR_W + 1);
    localparam int CW  = (SHW > IDLE_W) ? SHW : IDLE_W;
    localparam logic [IRL_W-1:0]  IRL_RST  = IRL_W'(4);
    localparam logic [ADDR_W-1:0] LAST_RST = ADDR_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] last_ir;
        logic [IRL_W-1:0]  ir_len;
        logic [PAD_W-1:0]  ir_pre;
        logic [PAD_W-1:0]  ir_post;
        logic [PAD_W-1:0]  dr_pre;
        logic [PAD_W-1:0]  dr_post;
        logic [IDLE_W-1:0] idle;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  len;
        logic              step_valid;
        logic              step_tms;
        logic              step_tdi;
        logic              step_cap;
        logic              cap_last;
        logic              rej;
    } seq_t;

    seq_t    d, q;
    tap_st_e tap_q, nav_tgt;
    logic    at_tgt, nav_tms;
    logic    sg_ir, sg_tms, sg_tdi, sg_cap, sg_cap_last;
    logic [PAD_W-1:0]  sg_pre, sg_post;
    logic [CW-1:0]     sg_nbits;
    logic [DATA_W-1:0] sg_pay, ir_pay;
    logic [ADDR_W:0]   max_addr, one_w;
    logic              bad_cmd;

    jseq_tap_track u_tap (
        .clk(clk), .rst_n(rst_n), .adv_i(d.step_valid), .tms_i(d.step_tms), .state_o(tap_q)
    );

    always_comb begin
        case (q.phase)
            PH_IR_GO:  nav_tgt = IR_SHIFT;
            PH_IR_UP:  nav_tgt = IR_UPD;
            PH_DR_GO:  nav_tgt = DR_SHIFT;
            PH_DR_UP:  nav_tgt = DR_UPD;
            default:   nav_tgt = TAP_IDLE;
        endcase
    end

    jseq_nav u_nav (.cur_i(tap_q), .tgt_i(nav_tgt), .at_tgt_o(at_tgt), .tms_o(nav_tms));

    always_comb begin
        ir_pay = '0;
        ir_pay[ADDR_W-1:0] = q.addr;
        sg_ir    = (q.phase == PH_IR_SH);
        sg_pre   = sg_ir ? q.ir_pre  : q.dr_pre;
        sg_post  = sg_ir ? q.ir_post : q.dr_post;
        sg_nbits = sg_ir ? CW'(q.ir_len) : CW'(q.len);
        sg_pay   = sg_ir ? ir_pay : q.data;
    end

    jseq_shift_gen #(.DATA_W(DATA_W), .PAD_W(PAD_W), .CW(CW)) u_shift (
        .idx_i(q.cnt), .pre_i(sg_pre), .nbits_i(sg_nbits), .post_i(sg_post),
        .payload_i(sg_pay), .pad_one_i(sg_ir), .cap_en_i(!sg_ir),
        .tms_o(sg_tms), .tdi_o(sg_tdi), .cap_o(sg_cap), .cap_last_o(sg_cap_last)
    );

    always_comb begin
        one_w    = {{ADDR_W{1'b0}}, 1'b1};
        max_addr = (one_w << q.ir_len) - one_w;
        bad_cmd  = ({1'b0, cmd_addr_i} > max_addr) || (cmd_len_i == '0) ||
                   (cmd_len_i > LEN_W'(DATA_W));
    end

    always_comb begin
        d = q;
        d.step_valid = 1'b0;
        d.step_tms   = 1'b0;
        d.step_tdi   = 1'b0;
        d.step_cap   = 1'b0;
        d.cap_last   = 1'b0;
        d.rej        = 1'b0;
        case (q.phase)
            PH_IDLE: if (cmd_valid_i) begin
                case (cmd_op_i)
                    OP_RESET: begin
                        d.phase = PH_RST;
                        d.cnt   = '0;
                    end
                    OP_SELECT: begin
                        d.ir_len  = cfg_ir_len_i;
                        d.ir_pre  = cfg_ir_pre_i;
                        d.ir_post = cfg_ir_post_i;
                        d.dr_pre  = cfg_dr_pre_i;
                        d.dr_post = cfg_dr_post_i;
                        d.idle    = cfg_idle_i;
                    end
                    OP_ACCESS: begin
                        if (bad_cmd) begin
                            d.rej = 1'b1;
                        end else begin
                            d.addr = cmd_addr_i;
                            d.data = cmd_data_i;
                            d.len  = cmd_len_i;
                            if (cmd_addr_i == q.last_ir) begin
                                d.phase = PH_DR_GO;
                            end else begin
                                d.phase   = PH_IR_GO;
                                d.last_ir = cmd_addr_i;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            PH_RST: begin
                d.step_valid = 1'b1;
                d.step_tms   = (q.cnt < CW'(RST_ONES));
                d.cnt        = q.cnt + CW'(1);
                if (q.cnt == CW'(RST_ONES)) d.phase = PH_IDLE;
            end
            PH_IR_GO, PH_IR_UP, PH_DR_GO, PH_DR_UP, PH_TO_RTI: begin
                if (at_tgt) begin
                    d.cnt = '0;
                    case (q.phase)
                        PH_IR_GO: d.phase = PH_IR_SH;
                        PH_IR_UP: d.phase = PH_DR_GO;
                        PH_DR_GO: d.phase = PH_DR_SH;
                        PH_DR_UP: d.phase = (q.idle != '0) ? PH_TO_RTI : PH_IDLE;
                        default:  d.phase = PH_WAIT;
                    endcase
                end else begin
                    d.step_valid = 1'b1;
                    d.step_tms   = nav_tms;
                end
            end
            PH_IR_SH, PH_DR_SH: begin
                d.step_valid = 1'b1;
                d.step_tms   = sg_tms;
                d.step_tdi   = sg_tdi;
                d.step_cap   = sg_cap;
                d.cap_last   = sg_cap_last;
                d.cnt        = q.cnt + CW'(1);
                if (sg_tms) d.phase = sg_ir ? PH_IR_UP : PH_DR_UP;
            end
            PH_WAIT: begin
                d.step_valid = 1'b1;
                d.cnt        = q.cnt + CW'(1);
                if (q.cnt == CW'(q.idle) - CW'(1)) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.phase   <= PH_IDLE;
            q.last_ir <= LAST_RST;
            q.ir_len  <= IRL_RST;
        end else begin
            q <= d;
        end
    end

    jseq_rsp u_rsp (
        .clk(clk), .rst_n(rst_n), .take_i(q.step_valid && q.step_cap),
        .bit_i(tdo_i), .last_i(q.cap_last),
        .valid_o(rsp_valid_o), .bit_o(rsp_bit_o), .last_o(rsp_last_o)
    );

    assign cmd_ready_o  = (q.phase == PH_IDLE);
    assign cmd_rej_o    = q.rej;
    assign step_valid_o = q.step_valid;
    assign step_tms_o   = q.step_tms;
    assign step_tdi_o   = q.step_tdi;
    assign step_cap_o   = q.step_cap;

    a_r1_reset_lands_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RST && q.cnt == CW'(RST_ONES)) |=> (tap_q == TAP_IDLE));

    a_r5_cap_only_dr_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_o && step_cap_o) |-> (tap_q inside {DR_SHIFT, DR_EXIT1}));

    a_r6_wait_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_WAIT) |-> (tap_q == TAP_IDLE));

    a_r8_rej_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rej_o |-> (cmd_ready_o && !step_valid_o));

    a_r9_rsp_tracks_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_o && step_cap_o) |=> (rsp_valid_o && rsp_bit_o == $past(tdo_i)));
endmodule

// File: tb/tb_jtag_scan_seq.sv
module tb_jtag_scan_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [7:0]  cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [5:0]  cmd_len = '0;
    logic [3:0]  cfg_ir_len = 4'd4;
    logic [3:0]  cfg_ir_pre = '0, cfg_ir_post = '0, cfg_dr_pre = '0, cfg_dr_post = '0;
    logic [7:0]  cfg_idle = '0;
    logic        cmd_rej, step_valid, step_tms, step_tdi, step_cap, tdo;
    logic        rsp_valid, rsp_bit, rsp_last;

    assign tdo = ~step_tdi;

    jtag_scan_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cmd_len_i(cmd_len),
        .cfg_ir_len_i(cfg_ir_len), .cfg_ir_pre_i(cfg_ir_pre), .cfg_ir_post_i(cfg_ir_post),
        .cfg_dr_pre_i(cfg_dr_pre), .cfg_dr_post_i(cfg_dr_post), .cfg_idle_i(cfg_idle),
        .cmd_rej_o(cmd_rej), .step_valid_o(step_valid), .step_tms_o(step_tms),
        .step_tdi_o(step_tdi), .step_cap_o(step_cap), .tdo_i(tdo),
        .rsp_valid_o(rsp_valid), .rsp_bit_o(rsp_bit), .rsp_last_o(rsp_last)
    );

    int tests = 0, fails = 0;
    int got_n = 0, rsp_n = 0, exp_n = 0;
    logic [2:0] got_s [512];
    logic [2:0] exp_s [512];
    logic [1:0] got_r [64];
    logic rej_seen = 1'b0;

    // bench view of the chain: loc 0=Test-Logic-Reset, 1=Run-Test/Idle, 2=Update-DR
    int loc = 0;
    int b_irlen = 4, b_ipre = 0, b_ipost = 0, b_dpre = 0, b_dpost = 0, b_idle = 0;

    always @(negedge clk) begin
        if (step_valid && got_n < 512) begin
            got_s[got_n] = {step_tms, step_tdi, step_cap};
            got_n = got_n + 1;
        end
        if (rsp_valid && rsp_n < 64) begin
            got_r[rsp_n] = {rsp_bit, rsp_last};
            rsp_n = rsp_n + 1;
        end
        if (cmd_rej) rej_seen = 1'b1;
    end

    task automatic push(input logic t, input logic d, input logic c);
        exp_s[exp_n] = {t, d, c};
        exp_n = exp_n + 1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] a,
                         input logic [31:0] dat, input logic [5:0] ln);
        got_n = 0; rsp_n = 0; rej_seen = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = dat; cmd_len = ln;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_steps(input string req);
        int bad = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (bad < 0 && got_s[i] !== exp_s[i]) bad = i;
        if (got_n != exp_n)
            check(0, req, "step count", got_n, exp_n);
        else if (bad >= 0)
            check(0, req, $sformatf("step %0d {tms,tdi,cap}", bad), got_s[bad], exp_s[bad]);
        else
            check(1, req, "steps", 0, 0);
    endtask

    task automatic check_rsp(input string req, input logic [31:0] dat, input int ln);
        int bad = -1;
        for (int i = 0; i < ln && i < rsp_n; i++)
            if (bad < 0 && got_r[i] !== {~dat[i], (i == ln - 1)}) bad = i;
        if (rsp_n != ln) check(0, req, "response count", rsp_n, ln);
        else if (bad >= 0)
            check(0, req, $sformatf("response %0d {bit,last}", bad), got_r[bad],
                  {~dat[bad], (bad == ln - 1)});
        else check(1, req, "response", 0, 0);
    endtask

    // Expected access sequence built from R2..R7.
    task automatic expect_access(input logic [7:0] a, input logic [31:0] dat,
                                 input int ln, input bit load);
        int tot;
        exp_n = 0;
        if (loc == 0) push(0, 0, 0);
        if (load) begin
            push(1, 0, 0); push(1, 0, 0); push(0, 0, 0); push(0, 0, 0);
            tot = b_ipre + b_irlen + b_ipost;
            for (int i = 0; i < tot; i++)
                push(i == tot - 1,
                     (i < b_ipre || i >= b_ipre + b_irlen) ? 1'b1 : a[i - b_ipre], 0);
            push(1, 0, 0);
        end
        push(1, 0, 0); push(0, 0, 0); push(0, 0, 0);
        tot = b_dpre + ln + b_dpost;
        for (int i = 0; i < tot; i++) begin
            logic pay;
            pay = (i >= b_dpre) && (i < b_dpre + ln);
            push(i == tot - 1, pay ? dat[i - b_dpre] : 1'b0, pay);
        end
        push(1, 0, 0);
        if (b_idle > 0) begin
            push(0, 0, 0);
            for (int i = 0; i < b_idle; i++) push(0, 0, 0);
            loc = 1;
        end else loc = 2;
    endtask

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [5:0]  len;
        logic        load;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd1,  32'h0000_00A5, 6'd8,  1'b0},   // R7 address 1 already loaded after reset
        '{8'd5,  32'h0000_0003, 6'd2,  1'b1},   // R3 new instruction
        '{8'd5,  32'hDEAD_BEEF, 6'd32, 1'b0},   // R7 skip, R4 full width
        '{8'd15, 32'h0000_0001, 6'd1,  1'b1}    // R8 boundary: max address accepted
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !step_valid && !rsp_valid && !cmd_rej, "R11", "reset state",
              {cmd_ready, step_valid, rsp_valid, cmd_rej}, 4'b1000);

        for (int v = 0; v < 4; v++) begin
            issue(2'd1, VECS[v].addr, VECS[v].data, VECS[v].len);
            expect_access(VECS[v].addr, VECS[v].data, int'(VECS[v].len), VECS[v].load);
            check_steps($sformatf("R2/R3/R4/R5/R7 vec%0d", v));
            check_rsp($sformatf("R9 vec%0d", v), VECS[v].data, int'(VECS[v].len));
        end

        issue(2'd1, 8'd16, 32'h1, 6'd4);       // R8 above default max 15
        check(rej_seen && got_n == 0, "R8", "addr 16 reject/steps", {rej_seen, got_n[7:0]}, 9'h100);
        issue(2'd1, 8'd15, 32'h1, 6'd0);       // R8 zero length
        check(rej_seen && got_n == 0, "R8", "len 0 reject/steps", {rej_seen, got_n[7:0]}, 9'h100);

        cfg_ir_len = 4'd6; cfg_ir_pre = 4'd2; cfg_ir_post = 4'd1;
        cfg_dr_pre = 4'd1; cfg_dr_post = 4'd3; cfg_idle = 8'd3;
        issue(2'd2, 8'd0, 32'h0, 6'd0);        // R10 select
        check(got_n == 0 && !rej_seen, "R10", "select emits nothing", got_n, 0);
        b_irlen = 6; b_ipre = 2; b_ipost = 1; b_dpre = 1; b_dpost = 3; b_idle = 3;

        issue(2'd1, 8'd40, 32'h2D, 6'd7);      // R3/R4 padding, R6 idle
        expect_access(8'd40, 32'h2D, 7, 1'b1);
        check_steps("R3/R4/R6/R10 padded load");
        check_rsp("R5/R9 padded load", 32'h2D, 7);

        issue(2'd1, 8'd40, 32'h155, 6'd10);    // R7 skip from Run-Test/Idle
        expect_access(8'd40, 32'h155, 10, 1'b0);
        check_steps("R6/R7 padded skip");
        check_rsp("R9 padded skip", 32'h155, 10);

        issue(2'd1, 8'd64, 32'h1, 6'd1);       // R8 above 2^6-1 after select
        check(rej_seen && got_n == 0, "R8", "addr 64 reject", {rej_seen, got_n[7:0]}, 9'h100);

        issue(2'd0, 8'd0, 32'h0, 6'd0);        // R1 reset
        exp_n = 0;
        for (int i = 0; i < 5; i++) push(1, 0, 0);
        push(0, 0, 0);
        check_steps("R1 reset");
        loc = 1;

        issue(2'd1, 8'd40, 32'h9, 6'd4);       // R1 ends in idle, R7 instruction kept
        expect_access(8'd40, 32'h9, 4, 1'b0);
        check_steps("R1/R7 after reset");
        check_rsp("R9 after reset", 32'h9, 4);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule